// File: doc/BRIEF.md
# Strided, Indexed and Segment Load Sequencer

This block turns one vectorised load into an ordered stream of memory read requests and then routes each returned word into the register file. A single start pulse captures the whole configuration: a base address, an element size, a stride, an optional vector of per-element offsets, a segment length, a vector length, a predicate mask with enable and invert controls, and the first destination register. From then on the block issues at most one request per cycle over a valid/ready handshake. Each request carries its byte address, its destination register and its element slot.

Four address forms come out of one datapath. A unit-stride load steps by the element size. A constant-stride load steps by a supplied stride. An indexed load takes each element's offset from the index vector. A segment load fans every element out over several consecutive destination registers. Masked-out elements are skipped and cost no cycle, so their destinations keep their old contents.

Responses arrive in request order. A small tag queue pairs each response with its register and slot, and the block writes the data back in the same cycle the response arrives. A one-cycle done pulse closes the operation once the last write-back has happened.

Top module: `seg_load_seq`

## Requirements
- R1: With `unit_i` = 1 the effective stride is the element size `esz_i`, zero-extended to the address width.
- R2: With `unit_i` = 0 the effective stride is `stride_i`.
- R3: With `indexed_i` = 0, element i has offset i × (seglen + 1) × stride.
- R4: With `indexed_i` = 1, element i has offset equal to entry i of `index_i`, which sits at bits [i*AW +: AW].
- R5: Each active element issues seglen + 1 requests in a row. Request j has address base + offset + j × stride, register (rd + j) mod NREG and slot i. Elements are issued in ascending order.
- R6: With `pred_en_i` = 1, element i is active only when `pred_i[i]` XOR `pred_inv_i` is 1. Elements at or above the vector length are never active.
- R7: With `pred_en_i` = 0, every element below `vl_i` is active.
- R8: Inactive elements produce no request and no write-back, so their destination register slots keep their previous values.
- R9: All address arithmetic wraps modulo 2^AW.
- R10: A request is presented with `req_valid_o` and taken when `req_ready_i` is high, at most one per cycle. While it stalls, address, register and slot hold steady.
- R11: Every `resp_valid_i` produces `wb_en_o` in the same cycle. The write-back carries `resp_data_i` together with the register and slot of the oldest request not yet answered.
- R12: `done_o` pulses for exactly one cycle, in the cycle after the final write-back, and `busy_o` falls after it. When no element is active, `done_o` comes in the first cycle after the start edge. After reset the block is idle, with `busy_o`, `req_valid_o` and `done_o` low.
- R13: A `start_i` pulse while `busy_o` is high is ignored, and the operation in flight continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| base_i | input | AW | Base byte address |
| esz_i | input | ESZW | Element size in bytes |
| unit_i | input | 1 | Use the element size as the stride |
| stride_i | input | AW | Constant stride |
| indexed_i | input | 1 | The offset operand is a vector (indexed form) |
| index_i | input | MAXVL*AW | Index vector; entry i at bits [i*AW +: AW] |
| seglen_i | input | SEGW | Segment length minus one |
| vl_i | input | VLW | Vector length (0..MAXVL) |
| pred_en_i | input | 1 | Predication enable |
| pred_inv_i | input | 1 | Invert the predicate test |
| pred_i | input | MAXVL | Predicate bits, one per element |
| rd_i | input | RW | First destination register |
| busy_o | output | 1 | Operation in progress |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | AW | Request byte address |
| req_reg_o | output | RW | Destination register of the request |
| req_slot_o | output | SLW | Element slot of the request |
| resp_valid_i | input | 1 | Read data returned (in order) |
| resp_data_i | input | DW | Returned data |
| wb_en_o | output | 1 | Register file write enable |
| wb_reg_o | output | RW | Write-back register |
| wb_slot_o | output | SLW | Write-back element slot |
| wb_data_o | output | DW | Write-back data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first request of an operation can be valid in the first cycle after the start edge. Each later request appears right after the previous handshake edge, with masked elements costing no cycle. Write-backs are combinational, in the same cycle as their response. `done_o` follows one cycle after the final write-back, or in the first cycle after the start edge when nothing is active. The bench changes inputs one time unit after each rising edge and samples every output one unit later, inside the same cycle. It then compares each handshake, write-back and done pulse against the cycle number its own model predicts.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/seg_load_mask.sv
module seg_load_mask #(
  parameter int MAXVL = 8,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic [VLW-1:0]   vl_i,
  input  logic             pen_i,
  input  logic             inv_i,
  input  logic [MAXVL-1:0] pred_i,
  output logic [MAXVL-1:0] mask_o
);
  // Per-element activity: inside the vector length, and either unpredicated
  // or passing the (optionally inverted) predicate bit.
  for (genvar k = 0; k < MAXVL; k++) begin : g_bit
    assign mask_o[k] = (VLW'(k) < vl_i) && (!pen_i || (pred_i[k] ^ inv_i));
  end
endmodule

// File: rtl/seg_load_walker.sv
module seg_load_walker #(
  parameter int AW    = 32,
  parameter int MAXVL = 8,
  parameter int NREG  = 32,
  parameter int SEGW  = 3,
  localparam int VLW = $clog2(MAXVL + 1),
  localparam int SLW = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int RW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    stride_i,
  input  logic             indexed_i,
  input  logic [MAXVL*AW-1:0] index_i,
  input  logic [SEGW-1:0]  seglen_i,
  input  logic [RW-1:0]    rd_i,
  input  logic [MAXVL-1:0] mask_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic             fire_i,
  output logic             cand_valid_o,
  output logic [AW-1:0]    addr_o,
  output logic [RW-1:0]    reg_o,
  output logic [SLW-1:0]   slot_o
);
  logic [AW-1:0]    base_q, stride_q;
  logic             indexed_q;
  logic [AW-1:0]    idx_q [MAXVL];
  logic [SEGW-1:0]  seglen_q, seg_q;
  logic [RW-1:0]    rd_q;
  logic [MAXVL-1:0] mask_q;
  logic [VLW-1:0]   vl_q, elem_q, cur;
  logic [AW-1:0]    elem_off;
  logic             seg_last;

  // First active element at or after 'from'; MAXVL when none remains.
  function automatic logic [VLW-1:0] pick_active(input logic [MAXVL-1:0] m,
                                                 input logic [VLW-1:0] from);
    logic [VLW-1:0] r;
    r = VLW'(MAXVL);
    for (int k = MAXVL - 1; k >= 0; k--)
      if (m[k] && (VLW'(k) >= from)) r = VLW'(k);
    return r;
  endfunction

  // Strided offset of an element, reduced modulo 2^AW.
  function automatic logic [AW-1:0] strided_off(input logic [VLW-1:0] i,
                                                input logic [SEGW-1:0] s,
                                                input logic [AW-1:0] st);
    logic [AW-1:0] span;
    span = AW'(i) * (AW'(s) + AW'(1));
    return span * st;
  endfunction

  // Address of field j of an element, reduced modulo 2^AW.
  function automatic logic [AW-1:0] field_addr(input logic [AW-1:0] b,
                                               input logic [AW-1:0] off,
                                               input logic [SEGW-1:0] j,
                                               input logic [AW-1:0] st);
    return b + off + (AW'(j) * st);
  endfunction

  assign cur          = pick_active(mask_q, elem_q);
  assign cand_valid_o = (cur < VLW'(MAXVL));
  assign slot_o       = cur[SLW-1:0];
  assign seg_last     = (seg_q == seglen_q);
  assign elem_off     = indexed_q ? idx_q[slot_o] : strided_off(cur, seglen_q, stride_q);
  assign addr_o       = field_addr(base_q, elem_off, seg_q, stride_q);
  assign reg_o        = rd_q + RW'(seg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      stride_q  <= '0;
      indexed_q <= 1'b0;
      seglen_q  <= '0;
      seg_q     <= '0;
      rd_q      <= '0;
      mask_q    <= '0;
      vl_q      <= '0;
      elem_q    <= '0;
    end else if (load_i) begin
      base_q    <= base_i;
      stride_q  <= stride_i;
      indexed_q <= indexed_i;
      seglen_q  <= seglen_i;
      seg_q     <= '0;
      rd_q      <= rd_i;
      mask_q    <= mask_i;
      vl_q      <= vl_i;
      elem_q    <= '0;
    end else if (fire_i) begin
      if (seg_last) begin
        seg_q  <= '0;
        elem_q <= cur + VLW'(1);
      end else begin
        seg_q  <= seg_q + SEGW'(1);
        elem_q <= cur;
      end
    end
  end

  for (genvar k = 0; k < MAXVL; k++) begin : g_idx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q[k] <= '0;
      else if (load_i) idx_q[k] <= index_i[k*AW +: AW];
    end
  end

  // R6: a presented element is one the captured mask enables
  assert_slot_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid_o |-> mask_q[slot_o]);
  // R7: no element at or beyond the captured vector length
  assert_slot_in_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid_o |-> (VLW'(slot_o) < vl_q));
  // R5: a non-final field keeps the element and moves on to the next register
  assert_seg_hold_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !load_i && !seg_last) |=> ($stable(slot_o) && (reg_o == $past(reg_o) + RW'(1))));
endmodule

// File: rtl/seg_load_tagq.sv
module seg_load_tagq #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head_o  = mem[rp];
  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= bump(wp);
      if (pop_i)  rp <= bump(rp);
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= data_i;
  end

  // R10: requests are only issued while a tag slot is free
  assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt < CW'(DEPTH)));
  // R11: every write-back pairs with an outstanding request
  assert_pop_tracked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt != '0));
endmodule

// File: rtl/seg_load_seq.sv
module seg_load_seq
  import seg_load_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int MAXVL  = 8,
  parameter int NREG   = 32,
  parameter int SEGW   = 3,
  parameter int ESZW   = 4,
  parameter int QDEPTH = 4,
  localparam int VLW = $clog2(MAXVL + 1),
  localparam int SLW = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-1:0]       base_i,
  input  logic [ESZW-1:0]     esz_i,
  input  logic                unit_i,
  input  logic [AW-1:0]       stride_i,
  input  logic                indexed_i,
  input  logic [MAXVL*AW-1:0] index_i,
  input  logic [SEGW-1:0]     seglen_i,
  input  logic [VLW-1:0]      vl_i,
  input  logic                pred_en_i,
  input  logic                pred_inv_i,
  input  logic [MAXVL-1:0]    pred_i,
  input  logic [RW-1:0]       rd_i,
  output logic                busy_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [AW-1:0]       req_addr_o,
  output logic [RW-1:0]       req_reg_o,
  output logic [SLW-1:0]      req_slot_o,
  input  logic                resp_valid_i,
  input  logic [DW-1:0]       resp_data_i,
  output logic                wb_en_o,
  output logic [RW-1:0]       wb_reg_o,
  output logic [SLW-1:0]      wb_slot_o,
  output logic [DW-1:0]       wb_data_o,
  output logic                done_o
);
  localparam int TW = RW + SLW;

  seq_state_e       state_q;
  logic             accept, fire, cand_valid, q_full, q_empty;
  logic [MAXVL-1:0] act_mask;
  logic [AW-1:0]    eff_stride;
  logic [TW-1:0]    tag_head;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign eff_stride = unit_i ? AW'(esz_i) : stride_i;

  seg_load_mask #(.MAXVL(MAXVL)) u_mask (
    .vl_i   (vl_i),
    .pen_i  (pred_en_i),
    .inv_i  (pred_inv_i),
    .pred_i (pred_i),
    .mask_o (act_mask)
  );

  seg_load_walker #(.AW(AW), .MAXVL(MAXVL), .NREG(NREG), .SEGW(SEGW)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (accept),
    .base_i       (base_i),
    .stride_i     (eff_stride),
    .indexed_i    (indexed_i),
    .index_i      (index_i),
    .seglen_i     (seglen_i),
    .rd_i         (rd_i),
    .mask_i       (act_mask),
    .vl_i         (vl_i),
    .fire_i       (fire),
    .cand_valid_o (cand_valid),
    .addr_o       (req_addr_o),
    .reg_o        (req_reg_o),
    .slot_o       (req_slot_o)
  );

  assign busy_o      = (state_q == ST_RUN);
  assign req_valid_o = busy_o && cand_valid && !q_full;
  assign fire        = req_valid_o && req_ready_i;
  assign wb_en_o     = resp_valid_i && !q_empty;
  assign done_o      = busy_o && !cand_valid && q_empty;

  seg_load_tagq #(.W(TW), .DEPTH(QDEPTH)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (fire),
    .data_i  ({req_reg_o, req_slot_o}),
    .pop_i   (wb_en_o),
    .head_o  (tag_head),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  assign wb_reg_o  = tag_head[TW-1:SLW];
  assign wb_slot_o = tag_head[SLW-1:0];
  assign wb_data_o = resp_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= ST_IDLE;
    else if (accept)             state_q <= ST_RUN;
    else if (done_o)             state_q <= ST_IDLE;
  end

  // R10: a stalled request holds its address, register and slot
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_reg_o) && $stable(req_slot_o)));
  // R12: the completion pulse lasts one cycle and ends the operation
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R13: a start while busy leaves the operation running
  assert_start_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: tb/seg_load_seq_test.sv
module seg_load_seq_test;
  localparam int AW = 32, DW = 32, MAXVL = 8, NREG = 32, SEGW = 3, ESZW = 4, QDEPTH = 4;
  localparam int VLW = $clog2(MAXVL + 1);
  localparam int SLW = $clog2(MAXVL);
  localparam int RW  = $clog2(NREG);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                start_i = 0, unit_i = 0, indexed_i = 0, pred_en_i = 0, pred_inv_i = 0;
  logic [AW-1:0]       base_i = 0, stride_i = 0;
  logic [ESZW-1:0]     esz_i = 0;
  logic [MAXVL*AW-1:0] index_i = 0;
  logic [SEGW-1:0]     seglen_i = 0;
  logic [VLW-1:0]      vl_i = 0;
  logic [MAXVL-1:0]    pred_i = 0;
  logic [RW-1:0]       rd_i = 0;
  logic                req_ready_i = 0, resp_valid_i = 0;
  logic [DW-1:0]       resp_data_i = 0;
  logic                busy_o, req_valid_o, wb_en_o, done_o;
  logic [AW-1:0]       req_addr_o;
  logic [RW-1:0]       req_reg_o, wb_reg_o;
  logic [SLW-1:0]      req_slot_o, wb_slot_o;
  logic [DW-1:0]       wb_data_o;

  seg_load_seq #(.AW(AW), .DW(DW), .MAXVL(MAXVL), .NREG(NREG), .SEGW(SEGW),
                 .ESZW(ESZW), .QDEPTH(QDEPTH)) uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [AW-1:0] ea[$];
  int            er[$], es[$];
  logic [DW-1:0] rq[$];
  logic [DW-1:0] rf [NREG][MAXVL];
  logic [DW-1:0] xrf[NREG][MAXVL];
  int ri, wi, start_tick, done_tick, last_wb, done_count;
  string tag;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] memd(input logic [AW-1:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0000_5A5A;
  endfunction

  // Bench model of the request sequence (R1-related stride, R3/R4 offsets, R5 fields, R6/R7 activity, R9 wrap)
  task automatic build_expect();
    longint unsigned st, off, a;
    ea.delete(); er.delete(); es.delete();
    st = unit_i ? longint'(esz_i) : longint'(stride_i);
    for (int i = 0; i < int'(vl_i); i++) begin
      bit act;
      act = pred_en_i ? (pred_i[i] != pred_inv_i) : 1'b1;
      if (!act) continue;
      for (int j = 0; j <= int'(seglen_i); j++) begin
        if (indexed_i) off = longint'(index_i[i*AW +: AW]);
        else           off = longint'(i) * (longint'(seglen_i) + 1) * st;
        a = (longint'(base_i) + off + longint'(j) * st) & 64'hFFFF_FFFF;
        ea.push_back(AW'(a));
        er.push_back((int'(rd_i) + j) % NREG);
        es.push_back(i);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    start_i     = 1'b0;
    req_ready_i = ($urandom % 4) != 0;
    if (rq.size() > 0 && ($urandom % 3) != 0) begin
      resp_valid_i = 1'b1;
      resp_data_i  = rq[0];
    end else begin
      resp_valid_i = 1'b0;
    end
    #1;
    cyc++;
    if (req_valid_o && req_ready_i) begin
      if (ri < ea.size())
        check(req_addr_o == ea[ri] && int'(req_reg_o) == er[ri] && int'(req_slot_o) == es[ri],
              {tag, " R5 request"}, {req_addr_o, 8'(req_reg_o), 8'(req_slot_o)},
              {ea[ri], 8'(er[ri]), 8'(es[ri])});
      else
        check(1'b0, {tag, " R8 extra request"}, req_addr_o, 0);
      rq.push_back(memd(req_addr_o));
      ri++;
    end
    if (resp_valid_i) begin
      check(wb_en_o == 1'b1, "R11 write-back enable", wb_en_o, 1);
      if (wi < er.size())
        check(int'(wb_reg_o) == er[wi] && int'(wb_slot_o) == es[wi] && wb_data_o == memd(ea[wi]),
              "R11 write-back tag", {8'(wb_reg_o), 8'(wb_slot_o)}, {8'(er[wi]), 8'(es[wi])});
      if (wb_en_o) rf[wb_reg_o][wb_slot_o] = wb_data_o;
      void'(rq.pop_front());
      wi++;
      last_wb = cyc;
    end
    if (done_o) begin
      done_count++;
      done_tick = cyc;
    end
  endtask

  task automatic init_rf();
    for (int r = 0; r < NREG; r++)
      for (int s = 0; s < MAXVL; s++) begin
        rf[r][s]  = {16'hC0DE, 8'(r), 8'(s)};
        xrf[r][s] = rf[r][s];
      end
  endtask

  // Runs one load with the configuration already on the inputs
  task automatic run_load(input string t, input bit poke_busy);
    int guard;
    tag = t;
    init_rf();
    build_expect();
    for (int k = 0; k < ea.size(); k++) xrf[er[k]][es[k]] = memd(ea[k]);
    ri = 0; wi = 0; done_count = 0; done_tick = -1; last_wb = -1;
    start_i = 1'b1;
    tick();
    start_tick = cyc;
    guard = 0;
    while (done_count == 0 && guard < 3000) begin
      if (poke_busy && guard == 2) begin
        // R13: a second start with a different set-up mid-operation
        start_i = 1'b1; base_i = 32'h1234_0000; vl_i = VLW'(1); seglen_i = '0; rd_i = '0;
      end
      tick();
      guard++;
    end
    check(guard < 3000, {tag, " R12 watchdog"}, guard, 0);
    tick();
    check(done_count == 1, {tag, " R12 single done"}, done_count, 1);
    check(!busy_o, {tag, " R12 idle after done"}, busy_o, 0);
    check(ri == ea.size(), {tag, " R5 request count"}, ri, ea.size());
    if (ea.size() == 0) check(done_tick == start_tick, {tag, " R12 done with nothing active"}, done_tick, start_tick);
    else                check(done_tick == last_wb + 1, {tag, " R12 done after last write-back"}, done_tick, last_wb + 1);
    begin
      int bad = 0;
      for (int r = 0; r < NREG; r++)
        for (int s = 0; s < MAXVL; s++)
          if (rf[r][s] !== xrf[r][s]) bad++;
      check(bad == 0, {tag, " R8 register file contents"}, bad, 0);
    end
  endtask

  initial begin
    // R12: reset state
    #2;
    check(!busy_o && !req_valid_o && !done_o, "R12 reset outputs", {busy_o, req_valid_o, done_o}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    check(!busy_o && !req_valid_o && !done_o, "R12 idle after reset", {busy_o, req_valid_o, done_o}, 0);

    // R1: unit stride, no segments, all active (R7)
    base_i = 32'h1000; esz_i = 4; unit_i = 1; stride_i = 32'hDEAD; indexed_i = 0;
    seglen_i = 0; vl_i = 8; pred_en_i = 0; pred_inv_i = 0; pred_i = 8'h00; rd_i = 5;
    run_load("R1 unit-stride", 0);

    // R2/R3: constant stride with segments, predicated (R6)
    unit_i = 0; stride_i = 32'h40; seglen_i = 2; pred_en_i = 1; pred_i = 8'b1010_0110; vl_i = 7; rd_i = 30;
    run_load("R2 R3 strided segment", 0);

    // R6: inverted predicate
    pred_inv_i = 1;
    run_load("R6 inverted", 0);

    // R6/R8: all masked out, done right after start
    pred_inv_i = 0; pred_i = 8'h00;
    run_load("R8 all masked", 0);

    // R12: zero vector length
    pred_en_i = 0; vl_i = 0;
    run_load("R12 zero length", 0);

    // R4: indexed with segments
    indexed_i = 1; vl_i = 8; seglen_i = 1; unit_i = 1; esz_i = 8;
    for (int k = 0; k < MAXVL; k++) index_i[k*AW +: AW] = 32'h100 * (MAXVL - k) + 32'(k);
    run_load("R4 indexed", 0);

    // R9: wrap-around of the address
    indexed_i = 0; unit_i = 0; base_i = 32'hFFFF_FFF0; stride_i = 32'h8000_0004; seglen_i = 3;
    run_load("R9 wrap", 0);

    // R13: start while busy is ignored
    base_i = 32'h2000; stride_i = 32'h10; seglen_i = 3; vl_i = 8; pred_en_i = 0; rd_i = 2;
    build_expect();
    run_load("R13 busy start", 1);

    // Constrained random mix covering R1..R11
    for (int n = 0; n < 40; n++) begin
      base_i     = $urandom;
      esz_i      = ESZW'(1 << ($urandom % 4));
      unit_i     = $urandom % 2;
      stride_i   = ($urandom % 2) ? 32'($urandom % 64) : $urandom;
      indexed_i  = ($urandom % 3) == 0;
      for (int k = 0; k < MAXVL; k++) index_i[k*AW +: AW] = $urandom;
      seglen_i   = SEGW'($urandom);
      vl_i       = VLW'($urandom % (MAXVL + 1));
      pred_en_i  = $urandom % 2;
      pred_inv_i = $urandom % 2;
      pred_i     = MAXVL'($urandom);
      rd_i       = RW'($urandom);
      run_load("R5 random", 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1789);
  end
endmodule